// File: doc/BRIEF.md
# Harmonic Number Measurement Counter

This block finds the integer multiplier N of a phase-locked loop whose output reaches it as a strobe train at N times 20 kHz. On a measure command it opens a counting window of 4 ms, built from the chip's 1 kHz time base strobe. The 1 kHz strobe is first halved to a 500 Hz strobe, and the window spans two periods of that strobe. Every input strobe admitted during the window enters a prescaler made of a divide-by-10 stage followed by a divide-by-8 stage. With the rate and window fixed, 80N strobes arrive, so the binary counter behind the prescaler ends at N with no further arithmetic. For example, N = 22 means a 440 kHz input, 1760 admitted strobes and a result of 0x16.

The result is 8 bits wide. If the count would pass 255 it stays at 255 and an overflow flag is raised. A done flag reports the end of the window. The result, done and overflow hold until the next measure command is accepted.

Top module: `harmonic_meter`

## Requirements
- R1: After reset, harmonicN is 0, done is 0 and overflow is 0.
- R2: A measureCmd sampled while no measurement is running opens the window at that edge and clears harmonicN, overflow, done and both prescaler stages at the same edge.
- R3: The window stays open up to and including the edge at which the fourth tick1k strobe since opening is sampled. A pulseStb sampled at that edge is still admitted.
- R4: harmonicN equals floor(P/80), written as an unsigned binary value with bit 0 the least significant, where P is the number of pulseStb strobes admitted in the window. The prescaler divides by 10 and then by 8. Example: 1760 strobes give 8'b00010110.
- R5: done rises exactly one clock after the edge that closes the window, and stays high until the next accepted measureCmd.
- R6: If floor(P/80) exceeds 255, harmonicN holds at 255 and overflow is 1. Otherwise overflow is 0.
- R7: pulseStb strobes sampled while the window is closed change neither harmonicN nor overflow.
- R8: A measureCmd sampled while a window is open, or in the cycle before done rises, is ignored: nothing is cleared and the window length is unchanged.
- R9: A remainder left in the prescaler by one measurement has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseStb | input | 1 | Synchronized one-cycle strobe per input pulse |
| measureCmd | input | 1 | Starts a measurement |
| tick1k | input | 1 | One-cycle strobe from the 1 kHz time base |
| harmonicN | output | 8 | Measured harmonic number, binary |
| done | output | 1 | Measurement finished, result valid |
| overflow | output | 1 | Result saturated at 255 |

## Verification
The effect of a measureCmd edge is already visible at the negedge that follows: the outputs are cleared and done is low. A strobe adds to harmonicN at the same edge where it completes a group of 80. Done is still low at the negedge just after the closing tick and high one clock later, and the bench checks both of those negedges. Strobes are driven outside the window, a command is issued in the middle of a window, a strobe is placed on the closing tick, and a remainder of 79 is left over for the next run. Each case is sampled at negedges counted from these register stages.

// File: rtl/hm_pkg.sv
package hm_pkg;

  // Strobes sent from the sequencing logic to the counting datapath
  typedef struct packed {
    logic clearAll;  // restart prescaler and result for a new measurement
    logic gateOpen;  // window open: admit input strobes
  } hmCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_OPEN   = 2'd1,
    ST_SETTLE = 2'd2
  } hmState_e;

endpackage

// File: rtl/hm_div_stage.sv
module hm_div_stage #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inc,
  output logic carry
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign carry = inc && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  // Stage never leaves its modulus range (R4)
  assert_stage_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  // Clear at start leaves no remainder (R9)
  assert_stage_cleared_R9: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cnt == '0));

endmodule

// File: rtl/hm_datapath.sv
module hm_datapath
  import hm_pkg::*;
#(
  parameter int DIV_FIRST  = 10,
  parameter int DIV_SECOND = 8,
  parameter int RESULT_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  hmCtrl_t             ctrl,
  input  logic                pulseStb,
  output logic [RESULT_W-1:0] resultCnt,
  output logic                ovfFlag
);
  localparam int STAGES = 2;
  localparam logic [RESULT_W-1:0] RESULT_MAX = {RESULT_W{1'b1}};

  logic [STAGES:0] chain;

  assign chain[0] = ctrl.gateOpen && pulseStb;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int STAGE_DIV = (g == 0) ? DIV_FIRST : DIV_SECOND;
    hm_div_stage #(.DIV(STAGE_DIV)) stage_i (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (ctrl.clearAll),
      .inc   (chain[g]),
      .carry (chain[g+1])
    );
  end

  logic unitStb;
  assign unitStb = chain[STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultCnt <= '0;
      ovfFlag   <= 1'b0;
    end else if (ctrl.clearAll) begin
      resultCnt <= '0;
      ovfFlag   <= 1'b0;
    end else if (unitStb) begin
      if (resultCnt == RESULT_MAX) begin
        ovfFlag <= 1'b1;
      end else begin
        resultCnt <= resultCnt + 1'b1;
      end
    end
  end

  // Overflow only ever accompanies a saturated result (R6)
  assert_ovf_saturated_R6: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> (resultCnt == RESULT_MAX));

  // Closed window: strobes leave the result alone (R7)
  assert_closed_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.gateOpen && !ctrl.clearAll) |=> ($stable(resultCnt) && $stable(ovfFlag)));

  // Result advances by at most one per clock (R4)
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clearAll && ctrl.gateOpen && resultCnt != RESULT_MAX) |=>
      (resultCnt == $past(resultCnt) || resultCnt == $past(resultCnt) + 1'b1));

endmodule

// File: rtl/hm_control.sv
module hm_control
  import hm_pkg::*;
#(
  parameter int TICKS_PER_HALF   = 2,
  parameter int HALFS_PER_WINDOW = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    measureCmd,
  input  logic    tick1k,
  output hmCtrl_t ctrl,
  output logic    doneFlag
);
  localparam int TW = (TICKS_PER_HALF > 2) ? $clog2(TICKS_PER_HALF) : 1;
  localparam int HW = (HALFS_PER_WINDOW > 2) ? $clog2(HALFS_PER_WINDOW) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_HALF - 1);
  localparam logic [HW-1:0] HALF_LAST = HW'(HALFS_PER_WINDOW - 1);

  hmState_e state;
  logic [TW-1:0] tickCnt;
  logic [HW-1:0] halfCnt;
  logic halfStb;
  logic windowEnd;
  logic accept;

  assign accept    = (state == ST_IDLE) && measureCmd;
  assign halfStb   = (state == ST_OPEN) && tick1k && (tickCnt == TICK_LAST);
  assign windowEnd = halfStb && (halfCnt == HALF_LAST);

  assign ctrl.clearAll = accept;
  assign ctrl.gateOpen = (state == ST_OPEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      halfCnt  <= '0;
      doneFlag <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (measureCmd) begin
            state    <= ST_OPEN;
            tickCnt  <= '0;
            halfCnt  <= '0;
            doneFlag <= 1'b0;
          end
        end
        ST_OPEN: begin
          if (tick1k) begin
            tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
          end
          if (halfStb) begin
            halfCnt <= (halfCnt == HALF_LAST) ? '0 : halfCnt + 1'b1;
          end
          if (windowEnd) begin
            state <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          state    <= ST_IDLE;
          doneFlag <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Window closes only on a time base strobe (R3)
  assert_close_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrl.gateOpen) |-> $past(tick1k));

  // Done rises exactly one clock after closing (R5)
  assert_done_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(state == ST_SETTLE));

  // Done holds until a new measurement is accepted (R5)
  assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !accept) |=> doneFlag);

  // Commands during a running measurement are dropped (R8)
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !ctrl.clearAll);

endmodule

// File: rtl/harmonic_meter.sv
module harmonic_meter
  import hm_pkg::*;
#(
  parameter int DIV_FIRST        = 10,
  parameter int DIV_SECOND       = 8,
  parameter int TICKS_PER_HALF   = 2,
  parameter int HALFS_PER_WINDOW = 2,
  parameter int RESULT_W         = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pulseStb,
  input  logic                measureCmd,
  input  logic                tick1k,
  output logic [RESULT_W-1:0] harmonicN,
  output logic                done,
  output logic                overflow
);
  hmCtrl_t ctrl;

  hm_control #(
    .TICKS_PER_HALF   (TICKS_PER_HALF),
    .HALFS_PER_WINDOW (HALFS_PER_WINDOW)
  ) control_i (
    .clk        (clk),
    .rstN       (rstN),
    .measureCmd (measureCmd),
    .tick1k     (tick1k),
    .ctrl       (ctrl),
    .doneFlag   (done)
  );

  hm_datapath #(
    .DIV_FIRST  (DIV_FIRST),
    .DIV_SECOND (DIV_SECOND),
    .RESULT_W   (RESULT_W)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .pulseStb  (pulseStb),
    .resultCnt (harmonicN),
    .ovfFlag   (overflow)
  );

  // Accepted command clears the outputs at the next edge (R2)
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> (harmonicN == '0 && !overflow && !done));

endmodule

// File: tb/harmonic_meter_tb_top.sv
module harmonic_meter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseStb = 1'b0;
  logic measureCmd = 1'b0;
  logic tick1k = 1'b0;
  logic [7:0] harmonicN;
  logic done;
  logic overflow;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  harmonic_meter dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .pulseStb   (pulseStb),
    .measureCmd (measureCmd),
    .tick1k     (tick1k),
    .harmonicN  (harmonicN),
    .done       (done),
    .overflow   (overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full measurement: total strobes split over the four tick intervals.
  task automatic runWindow(input int total, input bit lastOnTick, input bit midCmd);
    int expN;
    @(negedge clk) measureCmd = 1'b1;
    @(negedge clk) measureCmd = 1'b0;
    check("R2 result cleared", harmonicN, 0);
    check("R2 done cleared", done, 0);
    for (int i = 0; i < 4; i++) begin
      int n;
      n = total / 4 + ((i == 3) ? total % 4 : 0);
      if (lastOnTick && i == 3) n = n - 1;
      for (int k = 0; k < n; k++) begin
        pulseStb = 1'b1;
        @(negedge clk);
      end
      pulseStb = 1'b0;
      if (midCmd && i == 1) begin
        measureCmd = 1'b1;
        @(negedge clk) measureCmd = 1'b0;
      end
      tick1k = 1'b1;
      if (lastOnTick && i == 3) pulseStb = 1'b1;
      @(negedge clk);
      tick1k = 1'b0;
      pulseStb = 1'b0;
    end
    check("R5 done low right after close", done, 0);
    @(negedge clk);
    check("R5 done one clock after close", done, 1);
    expN = total / 80;
    check("R4/R6 result", harmonicN, (expN > 255) ? 255 : expN);
    check("R6 overflow", overflow, (expN > 255) ? 1 : 0);
  endtask

  task automatic testReset();
    check("R1 reset result", harmonicN, 0);
    check("R1 reset done", done, 0);
    check("R1 reset overflow", overflow, 0);
  endtask

  task automatic testWorkedCase();
    runWindow(1760, 1'b0, 1'b0);
    check("R4 N=22 bits 00010110", harmonicN, 8'b00010110);
  endtask

  task automatic testIgnoreOutside();
    // Strobes after the window closes
    for (int k = 0; k < 300; k++) begin
      pulseStb = 1'b1;
      @(negedge clk);
    end
    pulseStb = 1'b0;
    check("R7 result unchanged after close", harmonicN, 22);
    check("R5 done held", done, 1);
  endtask

  task automatic testEdgeTick();
    // 80 strobes, the last one on the closing tick
    runWindow(80, 1'b1, 1'b0);
    check("R3 strobe on closing tick counted", harmonicN, 1);
  endtask

  task automatic testRemainder();
    runWindow(80 * 3 + 79, 1'b0, 1'b0);
    check("R9 first run", harmonicN, 3);
    runWindow(1, 1'b0, 1'b0);
    check("R9 remainder discarded", harmonicN, 0);
  endtask

  task automatic testMidCommand();
    runWindow(80 * 7, 1'b0, 1'b1);
    check("R8 mid command ignored", harmonicN, 7);
  endtask

  task automatic testSaturate();
    runWindow(80 * 260, 1'b0, 1'b0);
    check("R6 saturated", harmonicN, 255);
    check("R6 overflow set", overflow, 1);
    runWindow(80 * 5 + 3, 1'b0, 1'b0);
    check("R2 overflow cleared by new run", overflow, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWorkedCase();
    testIgnoreOutside();
    testEdgeTick();
    testRemainder();
    testMidCommand();
    testSaturate();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule